// File: doc/BRIEF.md
# Glyph Serializer with Line Timebase

This block turns character glyph pattern bytes into a serial pixel stream and produces the horizontal timing that steps through the rows of a glyph. A fetch engine elsewhere pulses `load_i` once per character cell with the 8-bit pattern and that cell's invert flag. The block shifts the pattern out one pixel per pixel clock, most significant bit first. When the invert flag captured with the byte is set, it inverts every pixel of that cell. When a byte has been fully shifted out and no new byte follows, the output is held at blank (logic 0).

A free-running pixel-position counter sets the line period. It ignores loads and frame starts. It raises `hsync_o` for a programmable number of clocks near the start of each line. Each sync pulse advances a 3-bit glyph-row counter and a line counter. A frame-active output is high while the line count is in the 192-line active region. A frame-start strobe returns the row and line counters to zero.

Top module: `glyph_serializer`

## Requirements
- R1: A load captures `pattern_i`. On the clock edge that takes the load, pattern bit 7 appears on `video_o`. Bits 6 down to 0 follow, one per clock, on the next seven edges.
- R2: The `invert_i` value captured with a load sets the polarity of all 8 pixels of that cell. When it is 1, every pixel is inverted. Changes on `invert_i` while the cell is shifting have no effect.
- R3: Once all 8 pixels have been sent and no new load has arrived, `video_o` is 0 whatever the captured invert flag was.
- R4: A load that arrives while a byte is still shifting, including in the clock of its last pixel, restarts the output with the new byte's bit 7. No blank pixel is inserted.
- R5: The pixel position counter runs freely with a period of 207 clocks and is cleared only by reset. Position 0 is the clock after a reset edge. `hsync_o` is high while the position is in the range 8 to 8+`hs_width_i`-1. It never rises when `hs_width_i` is 0.
- R6: The row counter `row_o` advances by one, wrapping from 7 to 0, in the same cycle that `hsync_o` rises.
- R7: The line count advances together with the row counter and wraps after 262 lines. `frame_active_o` is 1 for lines 0 to 191 and 0 for lines 192 to 261.
- R8: `frame_start_i` clears the row and line counts on the next edge, so `row_o` is 0 and `frame_active_o` is 1. It takes priority over a row step on the same edge.
- R9: After reset, `video_o` is 0, `hsync_o` is 0, `row_o` is 0 and `frame_active_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Clears row and line counts |
| load_i | input | 1 | Load strobe for a new character cell |
| pattern_i | input | 8 | Glyph pattern byte, bit 7 shifted out first |
| invert_i | input | 1 | Invert flag for the cell being loaded |
| hs_width_i | input | 5 | Sync pulse width in clocks (0 disables the pulse) |
| video_o | output | 1 | Serial pixel output |
| hsync_o | output | 1 | Horizontal sync |
| row_o | output | 3 | Glyph row counter |
| frame_active_o | output | 1 | High during the 192 active lines |

## Verification
There are two pairs of collisions to test. The first pair is a row step and a frame start on the same edge. The bench watches its own model of the pixel position and raises `frame_start_i` exactly on the edge where sync is about to rise. It then expects `row_o` to read 0, not 1. The second pair is a new load and the shift of the final pixel of the previous byte. The bench streams all 256 patterns back to back every 8 clocks, and also restarts cells after 5 pixels. It expects every new cell to begin with no blank pixel and with its own invert flag.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

    localparam int GLYPH_BITS = 8;

    typedef struct packed {
        logic [GLYPH_BITS-1:0] bits;
        logic                  inv;
        logic [3:0]            left;
    } cell_t;

    typedef struct packed {
        logic       hsync;
        logic       step;
    } sync_t;

    function automatic logic cell_pixel(input cell_t c);
        return (c.left != 4'd0) ? (c.bits[GLYPH_BITS-1] ^ c.inv) : 1'b0;
    endfunction

    function automatic cell_t cell_advance(input cell_t c);
        cell_t n;
        n = c;
        if (c.left != 4'd0) begin
            n.bits = {c.bits[GLYPH_BITS-2:0], 1'b0};
            n.left = c.left - 4'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/glyph_shifter.sv
module glyph_shifter
    import glyph_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [GLYPH_BITS-1:0] pattern,
    input  logic                  invert,
    output logic                  video
);

    cell_t cell_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_q <= '0;
        end else if (load) begin
            cell_q.bits <= pattern;
            cell_q.inv  <= invert;
            cell_q.left <= 4'(GLYPH_BITS);
        end else begin
            cell_q <= cell_advance(cell_q);
        end
    end

    assign video = cell_pixel(cell_q);

endmodule

// File: rtl/line_timebase.sv
module line_timebase
    import glyph_pkg::*;
#(
    parameter int LINE_CLKS = 207,
    parameter int HS_START  = 8,
    parameter int HSW_BITS  = 5,
    localparam int HCNT_W   = $clog2(LINE_CLKS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HSW_BITS-1:0] hs_width,
    output logic [HCNT_W-1:0]   hpos,
    output sync_t               sync
);

    localparam logic [HCNT_W-1:0] LAST_POS = HCNT_W'(LINE_CLKS - 1);
    localparam logic [HCNT_W-1:0] PRE_POS  = HCNT_W'(HS_START - 1);

    logic [HCNT_W-1:0] hpos_q;
    int                offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos_q <= '0;
        end else if (hpos_q == LAST_POS) begin
            hpos_q <= '0;
        end else begin
            hpos_q <= hpos_q + 1'b1;
        end
    end

    always_comb begin
        offset     = int'(hpos_q) - HS_START;
        sync.hsync = (offset >= 0) && (offset < int'(hs_width));
        sync.step  = (hpos_q == PRE_POS) && (hs_width != '0);
    end

    assign hpos = hpos_q;

endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
    parameter int ROW_BITS     = 3,
    parameter int ACTIVE_LINES = 192,
    parameter int FRAME_LINES  = 262,
    localparam int LINE_W      = $clog2(FRAME_LINES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                step,
    output logic [ROW_BITS-1:0] row,
    output logic                active
);

    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FRAME_LINES - 1);
    localparam logic [LINE_W-1:0] ACT_LIM   = LINE_W'(ACTIVE_LINES);

    logic [ROW_BITS-1:0] row_q;
    logic [LINE_W-1:0]   line_q;

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            row_q  <= '0;
            line_q <= '0;
        end else if (step) begin
            row_q  <= row_q + 1'b1;
            line_q <= (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
        end
    end

    assign row    = row_q;
    assign active = line_q < ACT_LIM;

endmodule

// File: rtl/glyph_serializer.sv
module glyph_serializer
    import glyph_pkg::*;
#(
    parameter int ROW_BITS     = 3,
    parameter int LINE_CLKS    = 207,
    parameter int HS_START     = 8,
    parameter int HSW_BITS     = 5,
    parameter int ACTIVE_LINES = 192,
    parameter int FRAME_LINES  = 262
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_start_i,
    input  logic                  load_i,
    input  logic [GLYPH_BITS-1:0] pattern_i,
    input  logic                  invert_i,
    input  logic [HSW_BITS-1:0]   hs_width_i,
    output logic                  video_o,
    output logic                  hsync_o,
    output logic [ROW_BITS-1:0]   row_o,
    output logic                  frame_active_o
);

    localparam int HCNT_W = $clog2(LINE_CLKS);

    logic [HCNT_W-1:0] hpos;
    sync_t             sync;

    glyph_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load_i),
        .pattern (pattern_i),
        .invert  (invert_i),
        .video   (video_o)
    );

    line_timebase #(
        .LINE_CLKS (LINE_CLKS),
        .HS_START  (HS_START),
        .HSW_BITS  (HSW_BITS)
    ) u_tb (
        .clk      (clk),
        .rst      (rst),
        .hs_width (hs_width_i),
        .hpos     (hpos),
        .sync     (sync)
    );

    frame_counter #(
        .ROW_BITS     (ROW_BITS),
        .ACTIVE_LINES (ACTIVE_LINES),
        .FRAME_LINES  (FRAME_LINES)
    ) u_fc (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start_i),
        .step        (sync.step),
        .row         (row_o),
        .active      (frame_active_o)
    );

    assign hsync_o = sync.hsync;

endmodule

// File: rtl/glyph_serializer_chk.sv
module glyph_serializer_chk #(
    parameter int ROW_BITS = 3,
    parameter int HCNT_W   = 8,
    parameter int HSW_BITS = 5,
    parameter int HS_START = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                frame_start_i,
    input logic                load_i,
    input logic [HSW_BITS-1:0] hs_width_i,
    input logic                video_o,
    input logic                hsync_o,
    input logic [ROW_BITS-1:0] row_o,
    input logic                frame_active_o,
    input logic [HCNT_W-1:0]   hpos
);

    logic [3:0] since_load;

    always_ff @(posedge clk) begin
        if (rst)               since_load <= 4'd8;
        else if (load_i)       since_load <= 4'd0;
        else if (since_load != 4'd8) since_load <= since_load + 4'd1;
    end

    AST_BLANK_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (since_load == 4'd8) |-> !video_o); // R3

    AST_SYNC_RISE_POS: assert property (@(posedge clk) disable iff (rst)
        ($rose(hsync_o) && $stable(hs_width_i)) |-> (hpos == HCNT_W'(HS_START))); // R5

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        ($rose(hsync_o) && $stable(hs_width_i) && !$past(frame_start_i) && !$past(rst))
        |-> (row_o == ROW_BITS'($past(row_o) + 1'b1))); // R6

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$rose(hsync_o) && $stable(hs_width_i) && !$past(frame_start_i) && !$past(rst))
        |-> $stable(row_o)); // R6

    AST_ACTIVE_FALL: assert property (@(posedge clk) disable iff (rst)
        ($fell(frame_active_o) && $stable(hs_width_i)) |-> $rose(hsync_o)); // R7

    AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(frame_start_i) |-> (row_o == '0 && frame_active_o)); // R8

endmodule

bind glyph_serializer glyph_serializer_chk #(
    .ROW_BITS (ROW_BITS),
    .HCNT_W   ($clog2(LINE_CLKS)),
    .HSW_BITS (HSW_BITS),
    .HS_START (HS_START)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .frame_start_i  (frame_start_i),
    .load_i         (load_i),
    .hs_width_i     (hs_width_i),
    .video_o        (video_o),
    .hsync_o        (hsync_o),
    .row_o          (row_o),
    .frame_active_o (frame_active_o),
    .hpos           (hpos)
);

// File: tb/tb_glyph_serializer.sv
`timescale 1ns/1ps
module tb_glyph_serializer;

    localparam int LINES  = 207;
    localparam int HSS    = 8;
    localparam int FRAMEL = 262;
    localparam int ACTL   = 192;

    logic       clk = 0;
    logic       rst = 1;
    logic       fs = 0;
    logic       load = 0;
    logic [7:0] pat = 0;
    logic       inv = 0;
    logic [4:0] hsw = 5'd16;
    logic       video, hsync, fa;
    logic [2:0] row;

    int checks = 0;
    int errors = 0;
    string vtag = "R1";
    bit saw_inactive = 0;
    bit saw_reactive = 0;

    // bench model state
    int m_h = 0, m_row = 0, m_line = 0, m_left = 0;
    logic [7:0] m_sr = 0;
    logic       m_inv = 0;

    always #5 clk = ~clk;

    glyph_serializer dut (
        .clk(clk), .rst(rst), .frame_start_i(fs), .load_i(load),
        .pattern_i(pat), .invert_i(inv), .hs_width_i(hsw),
        .video_o(video), .hsync_o(hsync), .row_o(row), .frame_active_o(fa)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_h <= 0; m_row <= 0; m_line <= 0; m_left <= 0; m_sr <= 0; m_inv <= 0;
        end else begin
            m_h <= (m_h + 1) % LINES;
            if (fs) begin
                m_row <= 0; m_line <= 0;
            end else if (m_h == HSS - 1 && hsw != 0) begin
                m_row <= (m_row + 1) % 8;
                m_line <= (m_line + 1) % FRAMEL;
            end
            if (load) begin
                m_sr <= pat; m_inv <= inv; m_left <= 8;
            end else if (m_left > 0) begin
                m_sr <= m_sr << 1; m_left <= m_left - 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 hsync", int'(hsync), int'(m_h >= HSS && m_h < HSS + int'(hsw)));
            chk("R6 row", int'(row), m_row);
            chk("R7 frame_active", int'(fa), int'(m_line < ACTL));
            chk({vtag, " video"}, int'(video), (m_left > 0) ? int'(m_sr[7] ^ m_inv) : 0);
            if (!fa) saw_inactive = 1;
            if (saw_inactive && fa) saw_reactive = 1;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic one_cell(input logic [7:0] p, input logic iv, input int gap);
        load = 1; pat = p; inv = iv;
        tick();
        load = 0; pat = ~p; inv = ~iv;   // R2: late changes must be ignored
        repeat (gap - 1) tick();
    endtask

    initial begin
        #(1_900_000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        // R9: reset values
        chk("R9 video", int'(video), 0);
        chk("R9 hsync", int'(hsync), 0);
        chk("R9 row", int'(row), 0);
        chk("R9 frame_active", int'(fa), 1);
        rst = 0;
        tick();

        // R1/R2/R3: isolated cells, both polarities, followed by blank time
        vtag = "R1/R2/R3";
        for (int i = 0; i < 32; i++) begin
            one_cell(8'(i * 37 + 1), i[0], 12);
        end
        one_cell(8'hFF, 1'b1, 12);
        one_cell(8'h00, 1'b1, 12);
        one_cell(8'h80, 1'b0, 12);
        one_cell(8'h01, 1'b1, 12);

        // R4: every pattern streamed back to back, load in the last-pixel cycle
        vtag = "R4";
        for (int p = 0; p < 256; p++) begin
            one_cell(8'(p), p[3], 8);
        end
        // R4: restart after only five pixels
        for (int p = 0; p < 16; p++) begin
            one_cell(8'(p * 13 + 5), p[0], 5);
        end
        repeat (10) tick();

        // R5/R6: sync width sweep including zero
        vtag = "R3";
        foreach (hsw_list[k]) begin
            hsw = hsw_list[k];
            repeat (2 * LINES) tick();
        end
        hsw = 5'd16;

        // R8: frame start colliding with a row step
        repeat (3 * LINES) tick();
        while (m_h != HSS - 1) tick();
        fs = 1;
        tick();
        fs = 0;
        @(negedge clk);
        chk("R8 row cleared over step", int'(row), 0);
        chk("R8 frame_active", int'(fa), 1);
        tick();

        // R7: a full frame plus margin, active region ends and returns
        repeat (LINES * (FRAMEL + 2)) tick();
        chk("R7 saw inactive lines", int'(saw_inactive), 1);
        chk("R7 active after wrap", int'(saw_reactive), 1);

        // R8: frame start at an arbitrary point mid-line
        repeat (50) tick();
        fs = 1;
        tick();
        fs = 0;
        @(negedge clk);
        chk("R8 row cleared mid-line", int'(row), 0);
        tick();
        finish_run();
    end

    logic [4:0] hsw_list [5] = '{5'd0, 5'd1, 5'd3, 5'd16, 5'd31};

endmodule